// File: doc/BRIEF.md
# Codec Playback Register Sequencer

This block brings the speaker playback path of an audio codec up and tears it down again by issuing a fixed series of register writes over a simple write port. The port has an address, a data byte, a write strobe and a ready return. A write is presented with the strobe high and is held unchanged until ready is seen high in the same cycle. The serial transport that carries these writes to the codec lives outside this block.

A start pulse runs the bring-up phase. The block first writes the configuration registers, from sample rate through output volume. It then keeps the port quiet for a programmable number of cycles, so that a clock-multiplying loop can lock on the new sample rate. After that it writes the power-up word and takes the speaker amplifier out of power-save. A stop pulse runs the teardown phase, which undoes the steps in the opposite dependency order. A busy flag covers each phase, and a one-cycle done flag marks the end of each phase.

Top module: `codec_seq`

## Requirements
- R1: During and right after reset, busy, done and the write strobe are all low.
- R2: A start pulse accepted while idle issues eleven configuration writes, as (address=data) in hex and in this order: 05=27, 02=20, 03=08, 06=3C, 08=E1, 0B=00, 07=20, 09=91, 0C=91, 0A=28, 0D=28. The first write is presented in the cycle after the pulse.
- R3: While the strobe is high and ready is low, the address, data and strobe hold their values. A write is accepted on the edge where both strobe and ready are high, and the next write of the same phase is presented in the following cycle.
- R4: After the last configuration write is accepted, the strobe stays low for exactly LOCK_CYCLES cycles before the next write.
- R5: After the lock wait, two writes complete the bring-up: 00=74 (power up the converter and both amplifiers), then 02=A0 (leave speaker power-save).
- R6: A stop pulse accepted while idle issues three teardown writes in this order: 02=20, then 02=00, then 00=40. The first is presented in the cycle after the pulse.
- R7: Busy is high from the cycle after an accepted pulse until the final write of the phase is accepted. Whenever the strobe is high, busy is high.
- R8: Done is high for exactly one cycle, in the cycle after the final write of a phase is accepted. Busy is low in that cycle.
- R9: Start and stop pulses that arrive while busy are ignored, so the write stream of the running phase is unchanged.
- R10: If start and stop are high together while idle, start wins and the bring-up phase runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the bring-up phase (one-cycle pulse) |
| stop_i | input | 1 | Begin the teardown phase (one-cycle pulse) |
| bus_addr_o | output | 8 | Register address of the pending write |
| bus_data_o | output | 8 | Data byte of the pending write |
| bus_wr_o | output | 1 | Write strobe, held until accepted |
| bus_rdy_i | input | 1 | Target accepts the write when high with the strobe |
| busy_o | output | 1 | A phase is in progress |
| done_o | output | 1 | One-cycle pulse at the end of each phase |

## Verification
On every cycle, the assertions check that a stalled write holds its address and data, that the strobe never rises outside busy, and that done is a single cycle that follows an accepted write. They also check that the strobe stays low through the whole lock window after the final volume write, and that the first write of each phase, including the case where start and stop arrive together, is the correct one. Only the bench scenarios can show the full ordered content of each phase, with and without ready stalls, and that pulses arriving mid-phase leave the stream unchanged.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_LOCK,
        ST_PWR,
        ST_TEAR
    } seq_state_e;

    localparam int STEP_COUNT = 16;
    localparam int IDX_W      = $clog2(STEP_COUNT);

    // step index ranges for the three write groups
    localparam logic [IDX_W-1:0] CFG_FIRST  = IDX_W'(0);
    localparam logic [IDX_W-1:0] CFG_LAST   = IDX_W'(10);
    localparam logic [IDX_W-1:0] PWR_FIRST  = IDX_W'(11);
    localparam logic [IDX_W-1:0] PWR_LAST   = IDX_W'(12);
    localparam logic [IDX_W-1:0] TEAR_FIRST = IDX_W'(13);
    localparam logic [IDX_W-1:0] TEAR_LAST  = IDX_W'(15);

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } reg_write_t;

    function automatic reg_write_t step_lookup(input int idx);
        reg_write_t w;
        case (idx)
            0:  w = '{addr: 8'h05, data: 8'h27}; // sample rate
            1:  w = '{addr: 8'h02, data: 8'h20}; // route converter to speaker
            2:  w = '{addr: 8'h03, data: 8'h08}; // amplifier gain
            3:  w = '{addr: 8'h06, data: 8'h3C}; // limiter timing
            4:  w = '{addr: 8'h08, data: 8'hE1}; // limiter reference
            5:  w = '{addr: 8'h0B, data: 8'h00}; // limiter extra bits
            6:  w = '{addr: 8'h07, data: 8'h20}; // limiter enable
            7:  w = '{addr: 8'h09, data: 8'h91}; // input volume left
            8:  w = '{addr: 8'h0C, data: 8'h91}; // input volume right
            9:  w = '{addr: 8'h0A, data: 8'h28}; // output volume left
            10: w = '{addr: 8'h0D, data: 8'h28}; // output volume right
            11: w = '{addr: 8'h00, data: 8'h74}; // power up
            12: w = '{addr: 8'h02, data: 8'hA0}; // leave power-save
            13: w = '{addr: 8'h02, data: 8'h20}; // enter power-save
            14: w = '{addr: 8'h02, data: 8'h00}; // drop the route
            15: w = '{addr: 8'h00, data: 8'h40}; // power down
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/codec_seq_step_rom.sv
module codec_seq_step_rom
    import codec_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output reg_write_t       entry_o
);

    reg_write_t table_w [STEP_COUNT];

    for (genvar g = 0; g < STEP_COUNT; g++) begin : g_entry
        assign table_w[g] = step_lookup(g);
    end

    assign entry_o = table_w[idx_i];

endmodule

// File: rtl/codec_seq_lock_timer.sv
module codec_seq_lock_timer #(
    parameter int LOCK_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/codec_seq.sv
module codec_seq
    import codec_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    output logic [7:0] bus_addr_o,
    output logic [7:0] bus_data_o,
    output logic       bus_wr_o,
    input  logic       bus_rdy_i,
    output logic       busy_o,
    output logic       done_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_reg_t;

    seq_reg_t   seq_d, seq_q;
    reg_write_t cur_w;
    logic       lock_load;
    logic       lock_expired;
    logic       writing;
    logic       accepted;
    logic       at_last;

    codec_seq_step_rom u_rom (
        .idx_i   (seq_q.idx),
        .entry_o (cur_w)
    );

    codec_seq_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (lock_load),
        .expired_o (lock_expired)
    );

    always_comb begin
        writing = (seq_q.state == ST_CFG) || (seq_q.state == ST_PWR) ||
                  (seq_q.state == ST_TEAR);
        accepted = writing && bus_rdy_i;
        unique case (seq_q.state)
            ST_CFG:  at_last = (seq_q.idx == CFG_LAST);
            ST_PWR:  at_last = (seq_q.idx == PWR_LAST);
            ST_TEAR: at_last = (seq_q.idx == TEAR_LAST);
            default: at_last = 1'b0;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        lock_load  = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_CFG;
                    seq_d.idx   = CFG_FIRST;
                end else if (stop_i) begin
                    seq_d.state = ST_TEAR;
                    seq_d.idx   = TEAR_FIRST;
                end
            end
            ST_CFG: begin
                if (accepted) begin
                    if (at_last) begin
                        seq_d.state = ST_LOCK;
                        lock_load   = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            ST_LOCK: begin
                if (lock_expired) begin
                    seq_d.state = ST_PWR;
                    seq_d.idx   = PWR_FIRST;
                end
            end
            ST_PWR, ST_TEAR: begin
                if (accepted) begin
                    if (at_last) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, idx: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_wr_o   = writing;
    assign bus_addr_o = writing ? cur_w.addr : 8'h00;
    assign bus_data_o = writing ? cur_w.data : 8'h00;
    assign busy_o     = (seq_q.state != ST_IDLE);
    assign done_o     = seq_q.done;

endmodule

// File: rtl/codec_seq_chk.sv
module codec_seq_chk #(
    parameter int LOCK_CYCLES = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       stop_i,
    input logic [7:0] bus_addr_o,
    input logic [7:0] bus_data_o,
    input logic       bus_wr_o,
    input logic       bus_rdy_i,
    input logic       busy_o,
    input logic       done_o
);

    localparam int GAP_W = $clog2(LOCK_CYCLES + 1);

    logic [GAP_W-1:0] gap_q;

    // counts down the lock window that follows the last volume write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (bus_wr_o && bus_rdy_i && bus_addr_o == 8'h0D) begin
            gap_q <= GAP_W'(LOCK_CYCLES);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!bus_wr_o && !busy_o && !done_o));

    assert_first_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (bus_wr_o && bus_addr_o == 8'h05 && bus_data_o == 8'h27));

    assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && !bus_rdy_i) |=>
            (bus_wr_o && $stable(bus_addr_o) && $stable(bus_data_o)));

    assert_lock_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q != '0) |-> !bus_wr_o);

    assert_first_tear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && !start_i) |=>
            (bus_wr_o && bus_addr_o == 8'h02 && bus_data_o == 8'h20));

    assert_wr_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_o |-> busy_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_wr_o && bus_rdy_i));

    assert_pulse_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (start_i || stop_i)) |=> (busy_o || done_o));

    assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && stop_i) |=> (bus_addr_o == 8'h05));

endmodule

bind codec_seq codec_seq_chk #(
    .LOCK_CYCLES (LOCK_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .bus_addr_o (bus_addr_o),
    .bus_data_o (bus_data_o),
    .bus_wr_o   (bus_wr_o),
    .bus_rdy_i  (bus_rdy_i),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tb_codec_seq.sv
module tb_codec_seq;

    localparam int LK = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       bus_rdy_i = 1'b1;
    logic [7:0] bus_addr_o;
    logic [7:0] bus_data_o;
    logic       bus_wr_o;
    logic       busy_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    codec_seq #(.LOCK_CYCLES(LK)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .bus_addr_o (bus_addr_o),
        .bus_data_o (bus_data_o),
        .bus_wr_o   (bus_wr_o),
        .bus_rdy_i  (bus_rdy_i),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [7:0] d, input string req);
        exp_q.push_back({a, d});
        tag_q.push_back(req);
    endtask

    task automatic push_up();
        push(8'h05, 8'h27, "R2"); push(8'h02, 8'h20, "R2");
        push(8'h03, 8'h08, "R2"); push(8'h06, 8'h3C, "R2");
        push(8'h08, 8'hE1, "R2"); push(8'h0B, 8'h00, "R2");
        push(8'h07, 8'h20, "R2"); push(8'h09, 8'h91, "R2");
        push(8'h0C, 8'h91, "R2"); push(8'h0A, 8'h28, "R2");
        push(8'h0D, 8'h28, "R2");
        push(8'h00, 8'h74, "R5"); push(8'h02, 8'hA0, "R5");
    endtask

    task automatic push_down();
        push(8'h02, 8'h20, "R6"); push(8'h02, 8'h00, "R6"); push(8'h00, 8'h40, "R6");
    endtask

    task automatic pulse(input bit s, input bit p);
        @(posedge clk); #1;
        start_i = s; stop_i = p;
        @(posedge clk); #1;
        start_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1'b1;
                break;
            end
        end
        check(seen, req, "done pulse seen", int'(seen), 1);
        check(exp_q.size() == 0, req, "writes left over", exp_q.size(), 0);
    endtask

    // ready driver
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_rdy_i <= stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
    end

    // monitor
    bit          mon_on = 1'b0;
    bit          was_wait = 1'b0;
    logic [15:0] held = '0;
    bit          in_gap = 1'b0;
    int          gap_cnt = 0;
    bit          prev_done = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (was_wait) begin
                check(bus_wr_o && {bus_addr_o, bus_data_o} == held, "R3",
                      "held write", {bus_addr_o, bus_data_o}, held);
            end
            if (bus_wr_o) begin
                check(busy_o, "R7", "busy with strobe", busy_o, 1);
            end
            if (in_gap) begin
                if (bus_wr_o) begin
                    check(gap_cnt == LK, "R4", "lock gap cycles", gap_cnt, LK);
                    in_gap = 1'b0;
                end else begin
                    gap_cnt++;
                end
            end
            if (bus_wr_o && bus_rdy_i) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected write", {bus_addr_o, bus_data_o}, 0);
                end else begin
                    automatic logic [15:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check({bus_addr_o, bus_data_o} == e, t, "write",
                          {bus_addr_o, bus_data_o}, e);
                end
                if (bus_addr_o == 8'h0D) begin
                    in_gap = 1'b1;
                    gap_cnt = 0;
                end
            end
            if (done_o) begin
                check(!busy_o, "R8", "busy during done", busy_o, 0);
                check(!prev_done, "R8", "done longer than one cycle", 1, 0);
            end
            was_wait  = bus_wr_o && !bus_rdy_i;
            held      = {bus_addr_o, bus_data_o};
            prev_done = done_o;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !bus_wr_o, "R1", "outputs in reset",
              {busy_o, done_o, bus_wr_o}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !bus_wr_o, "R1", "outputs after reset",
              {busy_o, done_o, bus_wr_o}, 0);
        mon_on = 1'b1;

        // bring-up, ready always high
        push_up();
        pulse(1'b1, 1'b0);
        @(negedge clk);
        check(busy_o, "R7", "busy after start", busy_o, 1);
        wait_done("R8");
        @(negedge clk);
        check(!busy_o, "R7", "idle after bring-up", busy_o, 0);

        // teardown, ready always high
        push_down();
        pulse(1'b0, 1'b1);
        @(negedge clk);
        check(busy_o, "R7", "busy after stop", busy_o, 1);
        wait_done("R6");

        // bring-up with stalls and ignored pulses
        stall_mode = 1'b1;
        push_up();
        pulse(1'b1, 1'b0);
        repeat (4) @(posedge clk);
        pulse(1'b1, 1'b1);
        repeat (10) @(posedge clk);
        pulse(1'b0, 1'b1);
        wait_done("R9");

        // teardown with stalls and an ignored start
        push_down();
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        wait_done("R9");

        // simultaneous start and stop while idle
        stall_mode = 1'b0;
        push_up();
        pulse(1'b1, 1'b1);
        @(negedge clk);
        check(bus_wr_o && bus_addr_o == 8'h05, "R10", "start wins", bus_addr_o, 8'h05);
        wait_done("R10");

        push_down();
        pulse(1'b0, 1'b1);
        wait_done("R6");

        repeat (5) @(negedge clk);
        check(!busy_o && !bus_wr_o, "R7", "final idle", {busy_o, bus_wr_o}, 0);
        summary();
    end

endmodule